// File: doc/BRIEF.md
# Edge-Sensing External Interrupt Port

This block watches eight external pins and turns activity on them into per-pin interrupt requests for a downstream interrupt controller. Each pin has a two-bit sensitivity code that selects one of four modes: low level, rising edge, falling edge, or any edge. Every pin input passes through a two-flop synchronizer before any detection is done. Edges are found by comparing the synchronized value with its previous sample, and each detected edge is held in a sticky flag until software clears it.

A pin in low-level mode has no sticky flag. Its flag bit is the inverted synchronized pin, so it stays asserted for as long as the pin is held low. The same pins can also be driven: a direction register enables the output driver, and an output latch supplies the value driven. A pin raises its request only while its flag is set, its enable bit is set, and it is configured as an input.

A simple synchronous register bus gives access to all state. A write takes effect on the clock edge where `busWr` is high. A read is combinational from `busAddr`.

Top module: `edge_irq_port`

## Requirements
- R1: After reset the sensitivity, direction, enable, output-latch and flag registers read 0, `irqReq` and `pinOe` are 0, and the synchronized pin samples start at all-ones, so a high pin causes no flag.
- R2: The register addresses are 0 sensitivity (16 bits), 1 direction, 2 enable, 3 output latch, 4 pin level (read-only) and 5 flags. Registers 0 to 3 read back what was written. `pinOe` equals the direction register (1 = output) and `pinOut` equals the output latch.
- R3: In mode code 00 (low level, the pin n code sitting in sensitivity bits [2n+1:2n]), the pin's flag bit reads 1 exactly while the synchronized pin is low.
- R4: Writing 1 to the flag bit of a pin in low-level mode has no lasting effect while the pin stays low.
- R5: Mode code 01 sets the flag on a rising edge of the synchronized pin only.
- R6: Mode code 10 sets the flag on a falling edge only.
- R7: Mode code 11 sets the flag on both rising and falling edges.
- R8: A detected edge sets the flag even while the pin's enable bit is 0. Setting the enable bit later raises the request.
- R9: Writing to address 5 clears each edge flag whose data bit is 1 and leaves bits written 0 unchanged. With no write and no change of sensitivity, an edge flag never falls.
- R10: `irqReq[n]` is flag n AND enable n AND NOT direction n, so a pin configured as an output raises no request.
- R11: A pin change becomes visible in the pin-level register after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe for the register bus |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr`, zero-extended |
| pinIn | input | 8 | Raw external pin levels |
| pinOut | output | 8 | Value driven on pins configured as outputs |
| pinOe | output | 8 | Output enable per pin |
| irqReq | output | 8 | Per-pin interrupt request |

## Verification
A corrupted edge flag shows up on the flag register and, when the pin is enabled as an input, on `irqReq` during the first cycle after the bad update. A synchronizer stage that is lost or added moves the pin-level readback by one cycle. That is caught by sampling on each of the first two edges after a pin change. A wrong mode decode shows up as a flag that is missing or unexpected within three cycles of the stimulating edge. That is why every mode is driven through both pin transitions, each followed by a clear.

// File: rtl/edge_irq_pkg.sv
`timescale 1ns/1ps
package edge_irq_pkg;

  localparam logic [1:0] MODE_LEVEL = 2'b00;
  localparam logic [1:0] MODE_RISE  = 2'b01;
  localparam logic [1:0] MODE_FALL  = 2'b10;
  localparam logic [1:0] MODE_ANY   = 2'b11;

  typedef enum logic [2:0] {
    SEL_SENSE = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_IEN   = 3'd2,
    SEL_OUT   = 3'd3,
    SEL_LEVEL = 3'd4,
    SEL_FLAG  = 3'd5,
    SEL_NONE6 = 3'd6,
    SEL_NONE7 = 3'd7
  } regSel_t;

  typedef struct packed {
    logic wrSense;
    logic wrDir;
    logic wrIen;
    logic wrOut;
    logic wrFlag;
  } strobe_t;

endpackage

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb,
  output regSel_t           rdSel
);

  always_comb begin
    strb  = '0;
    rdSel = regSel_t'(busAddr[2:0]);
    if (busWr) begin
      case (regSel_t'(busAddr[2:0]))
        SEL_SENSE: strb.wrSense = 1'b1;
        SEL_DIR:   strb.wrDir   = 1'b1;
        SEL_IEN:   strb.wrIen   = 1'b1;
        SEL_OUT:   strb.wrOut   = 1'b1;
        SEL_FLAG:  strb.wrFlag  = 1'b1;
        default:   strb         = '0;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb) && ((|strb) -> busWr)); // R2

endmodule

// File: rtl/edge_irq_datapath.sv
`timescale 1ns/1ps
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  regSel_t             rdSel,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] irqReq
);

  localparam int SENSE_W = 2 * NUM_PINS;

  logic [SENSE_W-1:0]  senseReg;
  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] ienReg;
  logic [NUM_PINS-1:0] outReg;
  logic [NUM_PINS-1:0] syncA;
  logic [NUM_PINS-1:0] syncPin;
  logic [NUM_PINS-1:0] prevPin;
  logic [NUM_PINS-1:0] edgeFlag;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] levelMask;
  logic [NUM_PINS-1:0] flagView;
  logic [1:0]          armCnt;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseReg <= '0;
      dirReg   <= '0;
      ienReg   <= '0;
      outReg   <= '0;
    end else begin
      if (strb.wrSense) senseReg <= busWdata[SENSE_W-1:0];
      if (strb.wrDir)   dirReg   <= busWdata[NUM_PINS-1:0];
      if (strb.wrIen)   ienReg   <= busWdata[NUM_PINS-1:0];
      if (strb.wrOut)   outReg   <= busWdata[NUM_PINS-1:0];
    end
  end

  // two-flop synchronizer plus previous sample, idle-high after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '1;
      syncPin <= '1;
      prevPin <= '1;
      armCnt  <= '0;
    end else begin
      syncA   <= pinIn;
      syncPin <= syncA;
      prevPin <= syncPin;
      if (armCnt != 2'd2) armCnt <= armCnt + 2'd1;
    end
  end

  // per-pin detection and sticky flags
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [1:0] mode;
    logic       rise;
    logic       fall;

    assign mode = senseReg[2*p +: 2];
    assign rise = syncPin[p] & ~prevPin[p];
    assign fall = ~syncPin[p] & prevPin[p];

    always_comb begin
      case (mode)
        MODE_RISE: edgeHit[p] = rise;
        MODE_FALL: edgeHit[p] = fall;
        MODE_ANY:  edgeHit[p] = rise | fall;
        default:   edgeHit[p] = 1'b0;
      endcase
    end

    assign levelMask[p] = (mode == MODE_LEVEL);
    assign flagView[p]  = levelMask[p] ? ~syncPin[p] : edgeFlag[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeFlag[p] <= 1'b0;
      end else if (levelMask[p]) begin
        edgeFlag[p] <= 1'b0;
      end else if (edgeHit[p]) begin
        edgeFlag[p] <= 1'b1;
      end else if (strb.wrFlag && busWdata[p]) begin
        edgeFlag[p] <= 1'b0;
      end
    end
  end

  assign irqReq = flagView & ienReg & ~dirReg;
  assign pinOe  = dirReg;
  assign pinOut = outReg;

  always_comb begin
    busRdata = '0;
    case (rdSel)
      SEL_SENSE: busRdata[SENSE_W-1:0]  = senseReg;
      SEL_DIR:   busRdata[NUM_PINS-1:0] = dirReg;
      SEL_IEN:   busRdata[NUM_PINS-1:0] = ienReg;
      SEL_OUT:   busRdata[NUM_PINS-1:0] = outReg;
      SEL_LEVEL: busRdata[NUM_PINS-1:0] = syncPin;
      SEL_FLAG:  busRdata[NUM_PINS-1:0] = flagView;
      default:   busRdata = '0;
    endcase
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrFlag && !(|edgeHit)) |=> ((edgeFlag & $past(busWdata[NUM_PINS-1:0])) == '0)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrFlag && !strb.wrSense) |=> ((~edgeFlag & $past(edgeFlag)) == '0)); // R9

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrSense |=> ((edgeFlag & $past(levelMask)) == '0)); // R3

  AST_DIR_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDir && (busWdata[NUM_PINS-1:0] == '1)) |=> (irqReq == '0)); // R10

  AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt == 2'd2) |-> (syncPin == $past(pinIn, 2))); // R11

endmodule

// File: rtl/edge_irq_port.sv
`timescale 1ns/1ps
module edge_irq_port
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] irqReq
);

  strobe_t strb;
  regSel_t rdSel;

  edge_irq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  edge_irq_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqReq   (irqReq)
  );

endmodule

// File: tb/test_edge_irq_port.sv
`timescale 1ns/1ps
module test_edge_irq_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [7:0]  pinIn = 8'hFF;
  logic [7:0]  pinOut;
  logic [7:0]  pinOe;
  logic [7:0]  irqReq;

  // selector codes: 0..7 bus read address, 8 irqReq, 9 pinOe, 10 pinOut
  localparam int S_IRQ = 8;
  localparam int S_OE  = 9;
  localparam int S_OUT = 10;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  sampleReq = 1'b0;
  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_port i_edge_irq_port (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqReq(irqReq)
  );

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (sampleReq && q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.sel)
        S_IRQ:   act = {8'h00, irqReq};
        S_OE:    act = {8'h00, pinOe};
        S_OUT:   act = {8'h00, pinOut};
        default: act = busRdata;
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic check(input int sel, input logic [15:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    if (sel < 8) busAddr = sel[2:0];
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    sampleReq = 1'b1;
    @(negedge clk); #1;
    sampleReq = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic setPins(input logic [7:0] v, input int settle);
    @(posedge clk); #1;
    pinIn = v;
    idle(settle);
  endtask

  initial begin
    idle(3);
    @(posedge clk); #1 rstN = 1'b1;

    // R1 reset state
    check(0, 16'h0000, "R1 sense");
    check(1, 16'h0000, "R1 dir");
    check(2, 16'h0000, "R1 ien");
    check(3, 16'h0000, "R1 out");
    check(5, 16'h0000, "R1 flags");
    check(S_IRQ, 16'h0000, "R1 irq");
    check(S_OE, 16'h0000, "R1 oe");

    // R2 register access and pin drive
    wr(0, 16'hA5C3); check(0, 16'hA5C3, "R2 sense");
    wr(1, 16'h003C); check(1, 16'h003C, "R2 dir");
    check(S_OE, 16'h003C, "R2 oe");
    wr(3, 16'h005A); check(3, 16'h005A, "R2 out");
    check(S_OUT, 16'h005A, "R2 pinOut");
    wr(1, 16'h0000); wr(0, 16'h0000);

    // R11 synchronizer latency
    setPins(8'hFE, 0);
    check(4, 16'h00FF, "R11 one edge");
    check(4, 16'h00FE, "R11 two edges");

    // R3 / R4 low-level mode on pin 0
    check(5, 16'h0001, "R3 level flag");
    wr(2, 16'h0001); check(S_IRQ, 16'h0001, "R3 level irq");
    wr(5, 16'h0001); check(5, 16'h0001, "R4 w1c on level");
    check(S_IRQ, 16'h0001, "R4 irq stays");
    setPins(8'hFF, 3);
    check(5, 16'h0000, "R3 level released");
    check(S_IRQ, 16'h0000, "R3 irq released");

    // R5 rising on pin 1
    wr(0, 16'h0004); wr(2, 16'h0002);
    setPins(8'hFD, 4); check(5, 16'h0000, "R5 fall ignored");
    setPins(8'hFF, 4); check(5, 16'h0002, "R5 rise flag");
    check(S_IRQ, 16'h0002, "R5 irq");
    // R9 write-one-to-clear
    wr(5, 16'h00FD); check(5, 16'h0002, "R9 zero keeps");
    wr(5, 16'h0002); check(5, 16'h0000, "R9 one clears");

    // R6 falling on pin 2 (enable off -> also R8)
    wr(0, 16'h0024);
    setPins(8'hFB, 4); check(5, 16'h0004, "R6 fall flag");
    check(S_IRQ, 16'h0000, "R8 no irq without enable");
    wr(2, 16'h0006); check(S_IRQ, 16'h0004, "R8 enable later");
    // R10 direction masks request
    wr(1, 16'h0004); check(S_IRQ, 16'h0000, "R10 output masks");
    check(5, 16'h0004, "R10 flag kept");
    wr(1, 16'h0000); check(S_IRQ, 16'h0004, "R10 input again");
    wr(5, 16'h0004);
    setPins(8'hFF, 4); check(5, 16'h0000, "R6 rise ignored");

    // R7 any edge on pin 3
    wr(0, 16'h00E4);
    setPins(8'hF7, 4); check(5, 16'h0008, "R7 fall flag");
    wr(5, 16'h0008); check(5, 16'h0000, "R7 cleared");
    setPins(8'hFF, 4); check(5, 16'h0008, "R7 rise flag");
    wr(5, 16'h0008); check(5, 16'h0000, "R7 cleared again");

    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule